// File: doc/BRIEF.md
# Multi-Cycle Control Sequencer

This block is the finite-state controller of a small multi-cycle 32-bit processor. It reads the 6-bit opcode of the instruction currently held by the datapath, plus the zero and sign flags from the ALU. It walks each instruction through fetch, decode, execute, memory access and write-back. Each instruction stops at the first state after which it has nothing left to do. In every state it drives the steering and write strobes of the datapath. These are the next-PC source, the PC load strobe, the destination-register choice, the immediate extension mode, the register-file write, the data-memory write and the ALU operation.

Every instruction class takes its own path through the states. The PC load strobe is a falling-edge register. It is raised in the middle of an instruction's final state, so the program counter loads on the rising edge that begins the next fetch. The datapath must hold the opcode stable from the fetch cycle until the instruction's last state.

Top module: `ctl_seq`

## Requirements
- R1: Driving `rst_n` low forces the sequencer to fetch at once and clears `pc_we`. While reset is held, `pc_we`, `rf_we` and `mem_we` stay 0. After `rst_n` rises between two clock edges, the sequencer stays in fetch through the first two rising edges and enters decode on the third.
- R2: Opcode encodings are as follows (binary). ADD 000000, SUB 000001, ADDIU 000010, AND 010000, ANDI 010001, ORI 010010, XORI 010011, SLL 011000, SLTI 011100, SLT 011101, SW 100110, LW 100111, BEQ 110000, BNE 110001, BLTZ 110010, J 111000, JR 111001, JAL 111010. Every other value is unrecognised.
- R3: J, JR and JAL take two cycles: fetch, then decode. BEQ, BNE and BLTZ take three cycles: fetch, decode, then branch-execute.
- R4: SW takes four cycles: fetch, decode, memory-execute, then memory. LW adds a load write-back after memory, for five cycles. ADD, SUB, AND, SLL, SLT, ADDIU, ANDI, ORI, XORI and SLTI take four cycles: fetch, decode, arithmetic-execute, then arithmetic write-back.
- R5: An unrecognised opcode follows the arithmetic path (four cycles) and never raises `rf_we`.
- R6: `pc_we` changes only on falling clock edges. In the second half of an instruction's final cycle it reads 1. In every other cycle it reads 0.
- R7: `pc_src` is 2'b11 for JR and 2'b10 for J or JAL, during fetch and decode. It is 2'b01 during an execute state when the branch condition holds. In all other cases it is 2'b00.
- R8: The branch condition holds for BEQ when `alu_zero` is 1, for BNE when `alu_zero` is 0, and for BLTZ when `alu_sign` is 1. The flags have no effect on `pc_src` outside an execute state.
- R9: `reg_dst` is 2'b00 for JAL in decode. It is 2'b01 in either write-back state for ADDIU, ANDI, ORI, XORI, SLTI and LW. In all other cases it is 2'b10.
- R10: `ext_sign` is 0 in an execute state when the opcode is ANDI, ORI or XORI. In all other cases it is 1.
- R11: `rf_we` is 1 only in arithmetic write-back for a recognised opcode, in load write-back, and in decode for JAL.
- R12: `mem_we` is 1 only in the memory state for SW, and never together with `rf_we`.
- R13: `alu_op` depends on the opcode alone. It is 3'b000 for ADD, ADDIU, LW, SW and unrecognised opcodes. It is 3'b001 for SUB, BEQ, BNE and BLTZ. The remaining codes are 3'b010 for SLL, 3'b011 for ORI, 3'b100 for AND and ANDI, 3'b110 for SLT and SLTI, and 3'b111 for XORI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; states advance on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode | input | 6 | Opcode of the instruction held by the datapath |
| alu_zero | input | 1 | ALU result equals zero |
| alu_sign | input | 1 | ALU result sign bit |
| pc_src | output | 2 | Next-PC source: 00 sequential, 01 relative branch, 10 absolute jump, 11 register jump |
| pc_we | output | 1 | PC load strobe, registered on the falling edge |
| reg_dst | output | 2 | Destination register: 00 link, 01 rt field, 10 rd field |
| ext_sign | output | 1 | Immediate extension: 1 sign, 0 zero |
| rf_we | output | 1 | Register-file write enable |
| mem_we | output | 1 | Data-memory write enable |
| alu_op | output | 3 | ALU operation code |

## Verification
In the final cycle of a taken branch, the relative-branch select and the falling-edge PC strobe must appear together. In decode of JAL, the absolute-jump select, the link destination, the register write and the PC strobe all coincide. The bench runs taken and not-taken branches and JAL, and the per-cycle model checks every output in each of those cycles. A second pass drives the branch flags inverted in all non-execute cycles, so a select that leaked outside execute would show up. A mid-instruction reset, applied just after the strobe rises in the store's memory cycle, checks that the reset wins over the strobe.

// File: rtl/ctl_seq_pkg.sv
`timescale 1ns/1ps
package ctl_seq_pkg;

  localparam int OPC_W = 6;
  localparam int ALU_W = 3;
  localparam int PCS_W = 2;
  localparam int DST_W = 2;

  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OP_ADD   = 6'b000000;
  localparam opc_t OP_SUB   = 6'b000001;
  localparam opc_t OP_ADDIU = 6'b000010;
  localparam opc_t OP_AND   = 6'b010000;
  localparam opc_t OP_ANDI  = 6'b010001;
  localparam opc_t OP_ORI   = 6'b010010;
  localparam opc_t OP_XORI  = 6'b010011;
  localparam opc_t OP_SLL   = 6'b011000;
  localparam opc_t OP_SLTI  = 6'b011100;
  localparam opc_t OP_SLT   = 6'b011101;
  localparam opc_t OP_SW    = 6'b100110;
  localparam opc_t OP_LW    = 6'b100111;
  localparam opc_t OP_BEQ   = 6'b110000;
  localparam opc_t OP_BNE   = 6'b110001;
  localparam opc_t OP_BLTZ  = 6'b110010;
  localparam opc_t OP_J     = 6'b111000;
  localparam opc_t OP_JR    = 6'b111001;
  localparam opc_t OP_JAL   = 6'b111010;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EX_ARITH, ST_EX_BRANCH,
    ST_EX_MEM, ST_MEM, ST_WB_ARITH, ST_WB_LOAD
  } seq_state_e;

  typedef enum logic [2:0] {
    CL_JUMP, CL_BRANCH, CL_STORE, CL_LOAD, CL_ARITH, CL_UNKNOWN
  } op_class_e;

  typedef enum logic [1:0] { BR_EQ, BR_NE, BR_LTZ, BR_NONE } br_kind_e;

  localparam logic [PCS_W-1:0] PCS_SEQ = 2'b00;
  localparam logic [PCS_W-1:0] PCS_REL = 2'b01;
  localparam logic [PCS_W-1:0] PCS_ABS = 2'b10;
  localparam logic [PCS_W-1:0] PCS_REG = 2'b11;

  localparam logic [DST_W-1:0] DST_LINK = 2'b00;
  localparam logic [DST_W-1:0] DST_RT   = 2'b01;
  localparam logic [DST_W-1:0] DST_RD   = 2'b10;

  localparam logic [ALU_W-1:0] ALU_ADD = 3'b000;
  localparam logic [ALU_W-1:0] ALU_SUB = 3'b001;
  localparam logic [ALU_W-1:0] ALU_SLL = 3'b010;
  localparam logic [ALU_W-1:0] ALU_OR  = 3'b011;
  localparam logic [ALU_W-1:0] ALU_AND = 3'b100;
  localparam logic [ALU_W-1:0] ALU_SLT = 3'b110;
  localparam logic [ALU_W-1:0] ALU_XOR = 3'b111;

  typedef struct packed {
    op_class_e        cls;
    logic             jmp_reg;
    logic             jmp_abs;
    logic             link;
    logic             dst_rt;
    logic             zero_ext;
    br_kind_e         br;
    logic [ALU_W-1:0] alu;
  } op_info_t;

endpackage

// File: rtl/ctl_seq_rst_sync.sv
`timescale 1ns/1ps
module ctl_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0] chain_q;

  generate
    if (N == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[N-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[N-1];

endmodule

// File: rtl/ctl_seq_decode.sv
`timescale 1ns/1ps
module ctl_seq_decode
  import ctl_seq_pkg::*;
(
  input  opc_t     opcode,
  output op_info_t info
);

  always_comb begin
    info          = '0;
    info.cls      = CL_UNKNOWN;
    info.br       = BR_NONE;
    info.alu      = ALU_ADD;
    case (opcode)
      OP_ADD:   begin info.cls = CL_ARITH; info.alu = ALU_ADD; end
      OP_SUB:   begin info.cls = CL_ARITH; info.alu = ALU_SUB; end
      OP_AND:   begin info.cls = CL_ARITH; info.alu = ALU_AND; end
      OP_SLL:   begin info.cls = CL_ARITH; info.alu = ALU_SLL; end
      OP_SLT:   begin info.cls = CL_ARITH; info.alu = ALU_SLT; end
      OP_ADDIU: begin info.cls = CL_ARITH; info.alu = ALU_ADD; info.dst_rt = 1'b1; end
      OP_SLTI:  begin info.cls = CL_ARITH; info.alu = ALU_SLT; info.dst_rt = 1'b1; end
      OP_ANDI: begin
        info.cls = CL_ARITH; info.alu = ALU_AND;
        info.dst_rt = 1'b1; info.zero_ext = 1'b1;
      end
      OP_ORI: begin
        info.cls = CL_ARITH; info.alu = ALU_OR;
        info.dst_rt = 1'b1; info.zero_ext = 1'b1;
      end
      OP_XORI: begin
        info.cls = CL_ARITH; info.alu = ALU_XOR;
        info.dst_rt = 1'b1; info.zero_ext = 1'b1;
      end
      OP_SW:   begin info.cls = CL_STORE; info.alu = ALU_ADD; end
      OP_LW:   begin info.cls = CL_LOAD;  info.alu = ALU_ADD; info.dst_rt = 1'b1; end
      OP_BEQ:  begin info.cls = CL_BRANCH; info.alu = ALU_SUB; info.br = BR_EQ;  end
      OP_BNE:  begin info.cls = CL_BRANCH; info.alu = ALU_SUB; info.br = BR_NE;  end
      OP_BLTZ: begin info.cls = CL_BRANCH; info.alu = ALU_SUB; info.br = BR_LTZ; end
      OP_J:    begin info.cls = CL_JUMP; info.jmp_abs = 1'b1; end
      OP_JAL:  begin info.cls = CL_JUMP; info.jmp_abs = 1'b1; info.link = 1'b1; end
      OP_JR:   begin info.cls = CL_JUMP; info.jmp_reg = 1'b1; end
      default: begin info.cls = CL_UNKNOWN; end
    endcase
  end

endmodule

// File: rtl/ctl_seq_fsm.sv
`timescale 1ns/1ps
module ctl_seq_fsm
  import ctl_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_class_e  cls,
  output seq_state_e state_q,
  output logic       last
);

  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CL_JUMP:            state_d = ST_FETCH;
          CL_BRANCH:          state_d = ST_EX_BRANCH;
          CL_STORE, CL_LOAD:  state_d = ST_EX_MEM;
          default:            state_d = ST_EX_ARITH;
        endcase
      end
      ST_EX_ARITH:  state_d = ST_WB_ARITH;
      ST_EX_BRANCH: state_d = ST_FETCH;
      ST_EX_MEM:    state_d = ST_MEM;
      ST_MEM:       state_d = (cls == CL_LOAD) ? ST_WB_LOAD : ST_FETCH;
      ST_WB_ARITH:  state_d = ST_FETCH;
      ST_WB_LOAD:   state_d = ST_FETCH;
      default:      state_d = ST_FETCH;
    endcase
  end

  // An instruction ends in any state that hands control back to fetch.
  assign last = (state_q != ST_FETCH) && (state_d == ST_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ctl_seq_ctrl.sv
`timescale 1ns/1ps
module ctl_seq_ctrl
  import ctl_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_e       state,
  input  op_info_t         info,
  input  logic             last,
  input  logic             alu_zero,
  input  logic             alu_sign,
  output logic [PCS_W-1:0] pc_src,
  output logic             pc_we,
  output logic [DST_W-1:0] reg_dst,
  output logic             ext_sign,
  output logic             rf_we,
  output logic             mem_we,
  output logic [ALU_W-1:0] alu_op
);

  logic early;
  logic in_exe;
  logic in_wb;
  logic taken;
  logic pc_we_q;

  assign early  = (state == ST_FETCH) || (state == ST_DECODE);
  assign in_exe = (state == ST_EX_ARITH) || (state == ST_EX_BRANCH) || (state == ST_EX_MEM);
  assign in_wb  = (state == ST_WB_ARITH) || (state == ST_WB_LOAD);

  always_comb begin
    case (info.br)
      BR_EQ:   taken = alu_zero;
      BR_NE:   taken = !alu_zero;
      BR_LTZ:  taken = alu_sign;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    if (early && info.jmp_reg)      pc_src = PCS_REG;
    else if (early && info.jmp_abs) pc_src = PCS_ABS;
    else if (in_exe && taken)       pc_src = PCS_REL;
    else                            pc_src = PCS_SEQ;
  end

  always_comb begin
    if ((state == ST_DECODE) && info.link) reg_dst = DST_LINK;
    else if (in_wb && info.dst_rt)         reg_dst = DST_RT;
    else                                   reg_dst = DST_RD;
  end

  assign ext_sign = !(in_exe && info.zero_ext);
  assign rf_we    = ((state == ST_WB_ARITH) && (info.cls != CL_UNKNOWN))
                 || (state == ST_WB_LOAD)
                 || ((state == ST_DECODE) && info.link);
  assign mem_we   = (state == ST_MEM) && (info.cls == CL_STORE);
  assign alu_op   = info.alu;

  // PC strobe registered mid-cycle so the PC loads on the edge that starts fetch.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pc_we_q <= 1'b0;
    else        pc_we_q <= last;
  end

  assign pc_we = pc_we_q;

endmodule

// File: rtl/ctl_seq.sv
`timescale 1ns/1ps
module ctl_seq
  import ctl_seq_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_zero,
  input  logic             alu_sign,
  output logic [PCS_W-1:0] pc_src,
  output logic             pc_we,
  output logic [DST_W-1:0] reg_dst,
  output logic             ext_sign,
  output logic             rf_we,
  output logic             mem_we,
  output logic [ALU_W-1:0] alu_op
);

  logic       rst_sync_n;
  op_info_t   info;
  seq_state_e state_q;
  logic       last;

  ctl_seq_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ctl_seq_decode u_dec (
    .opcode (opcode),
    .info   (info)
  );

  ctl_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cls     (info.cls),
    .state_q (state_q),
    .last    (last)
  );

  ctl_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .state    (state_q),
    .info     (info),
    .last     (last),
    .alu_zero (alu_zero),
    .alu_sign (alu_sign),
    .pc_src   (pc_src),
    .pc_we    (pc_we),
    .reg_dst  (reg_dst),
    .ext_sign (ext_sign),
    .rf_we    (rf_we),
    .mem_we   (mem_we),
    .alu_op   (alu_op)
  );

endmodule

// File: rtl/ctl_seq_chk.sv
`timescale 1ns/1ps
module ctl_seq_chk
  import ctl_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input seq_state_e       state,
  input logic [PCS_W-1:0] pc_src,
  input logic             pc_we,
  input logic [DST_W-1:0] reg_dst,
  input logic             ext_sign,
  input logic             rf_we,
  input logic             mem_we
);

  p_pcwe_then_fetch_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pc_we |=> (state == ST_FETCH));

  p_fetch_no_pcwe_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_FETCH) |-> !pc_we);

  p_jump_early_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pc_src == PCS_ABS) || (pc_src == PCS_REG)) |-> ((state == ST_FETCH) || (state == ST_DECODE)));

  p_rel_final_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pc_src == PCS_REL) |-> (pc_we && (state == ST_EX_BRANCH)));

  p_link_decode_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_dst == DST_LINK) |-> (rf_we && (state == ST_DECODE)));

  p_zext_then_wb_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ext_sign |=> (state == ST_WB_ARITH));

  p_rfwe_final_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rf_we |-> pc_we);

  p_memwe_final_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> (pc_we && (state == ST_MEM)));

  p_we_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({rf_we, mem_we}));

endmodule

bind ctl_seq ctl_seq_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .state      (state_q),
  .pc_src     (pc_src),
  .pc_we      (pc_we),
  .reg_dst    (reg_dst),
  .ext_sign   (ext_sign),
  .rf_we      (rf_we),
  .mem_we     (mem_we)
);

// File: tb/test_ctl_seq.sv
`timescale 1ns/1ps
module test_ctl_seq;

  localparam logic [5:0] C_ADD = 6'b000000, C_SUB = 6'b000001, C_ADDIU = 6'b000010;
  localparam logic [5:0] C_AND = 6'b010000, C_ANDI = 6'b010001, C_ORI = 6'b010010;
  localparam logic [5:0] C_XORI = 6'b010011, C_SLL = 6'b011000, C_SLTI = 6'b011100;
  localparam logic [5:0] C_SLT = 6'b011101, C_SW = 6'b100110, C_LW = 6'b100111;
  localparam logic [5:0] C_BEQ = 6'b110000, C_BNE = 6'b110001, C_BLTZ = 6'b110010;
  localparam logic [5:0] C_J = 6'b111000, C_JR = 6'b111001, C_JAL = 6'b111010;
  localparam logic [5:0] C_BAD = 6'b101010;

  // bench state numbering: 0 fetch, 1 decode, 2 ex-arith, 3 ex-branch,
  // 4 ex-mem, 5 mem, 6 wb-arith, 7 wb-load
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opc;
  logic       zf, sf;
  logic [1:0] pc_src, reg_dst;
  logic       pc_we, ext_sign, rf_we, mem_we;
  logic [2:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctl_seq i_ctl_seq (
    .clk(clk), .rst_n(rst_n), .opcode(opc), .alu_zero(zf), .alu_sign(sf),
    .pc_src(pc_src), .pc_we(pc_we), .reg_dst(reg_dst), .ext_sign(ext_sign),
    .rf_we(rf_we), .mem_we(mem_we), .alu_op(alu_op)
  );

  function automatic int cls_of(logic [5:0] op);
    // 0 jump, 1 branch, 2 store, 3 load, 4 arith, 5 unknown
    if (op == C_J || op == C_JR || op == C_JAL) return 0;
    if (op == C_BEQ || op == C_BNE || op == C_BLTZ) return 1;
    if (op == C_SW) return 2;
    if (op == C_LW) return 3;
    if (op == C_ADD || op == C_SUB || op == C_AND || op == C_SLL || op == C_SLT ||
        op == C_ADDIU || op == C_ANDI || op == C_ORI || op == C_XORI || op == C_SLTI) return 4;
    return 5;
  endfunction

  function automatic int n_states(logic [5:0] op);
    int c = cls_of(op);
    if (c == 0) return 2;
    if (c == 1) return 3;
    if (c == 3) return 5;
    return 4;
  endfunction

  function automatic int st_at(logic [5:0] op, int k);
    int c = cls_of(op);
    if (k < 2) return k;
    if (k == 2) return (c == 1) ? 3 : ((c == 2 || c == 3) ? 4 : 2);
    if (k == 3) return (c == 2 || c == 3) ? 5 : 6;
    return 7;
  endfunction

  function automatic string path_req(logic [5:0] op);
    int c = cls_of(op);
    if (c <= 1) return "R3";
    if (c == 5) return "R5";
    return "R4";
  endfunction

  function automatic int exp_pcsrc(int st, logic [5:0] op, logic z, logic s);
    bit ex = (st >= 2 && st <= 4);
    if (st <= 1 && op == C_JR) return 3;
    if (st <= 1 && (op == C_J || op == C_JAL)) return 2;
    if (ex && ((op == C_BEQ && z) || (op == C_BNE && !z) || (op == C_BLTZ && s))) return 1;
    return 0;
  endfunction

  function automatic int exp_dst(int st, logic [5:0] op);
    if (st == 1 && op == C_JAL) return 0;
    if ((st == 6 || st == 7) && (op == C_ADDIU || op == C_ANDI || op == C_ORI ||
        op == C_XORI || op == C_SLTI || op == C_LW)) return 1;
    return 2;
  endfunction

  function automatic int exp_ext(int st, logic [5:0] op);
    if (st >= 2 && st <= 4 && (op == C_ANDI || op == C_ORI || op == C_XORI)) return 0;
    return 1;
  endfunction

  function automatic int exp_rf(int st, logic [5:0] op);
    if (st == 6 && cls_of(op) != 5) return 1;
    if (st == 7) return 1;
    if (st == 1 && op == C_JAL) return 1;
    return 0;
  endfunction

  function automatic int exp_alu(logic [5:0] op);
    case (op)
      C_SUB, C_BEQ, C_BNE, C_BLTZ: return 1;
      C_SLL:                        return 2;
      C_ORI:                        return 3;
      C_AND, C_ANDI:                return 4;
      C_SLT, C_SLTI:                return 6;
      C_XORI:                       return 7;
      default:                      return 0;
    endcase
  endfunction

  task automatic chk(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d op=%b t=%0t", req, name, act, exp, opc, $time);
    end
  endtask

  // Entered 1 ns after a rising edge in the fetch cycle; leaves likewise.
  task automatic run_instr(logic [5:0] op, logic z, logic s, bit noisy);
    int n = n_states(op);
    opc = op;
    for (int k = 0; k < n; k++) begin
      int st = st_at(op, k);
      bit ex = (st >= 2 && st <= 4);
      zf = (noisy && !ex) ? ~z : z;
      sf = (noisy && !ex) ? ~s : s;
      #3;
      chk({"R6 ", path_req(op)}, "pc_we", int'(pc_we), (k == n - 1) ? 1 : 0);
      chk("R7 R8", "pc_src", int'(pc_src), exp_pcsrc(st, op, zf, sf));
      chk("R9", "reg_dst", int'(reg_dst), exp_dst(st, op));
      chk("R10", "ext_sign", int'(ext_sign), exp_ext(st, op));
      chk(cls_of(op) == 5 ? "R5 R11" : "R11", "rf_we", int'(rf_we), exp_rf(st, op));
      chk("R12", "mem_we", int'(mem_we), (st == 5 && op == C_SW) ? 1 : 0);
      chk("R13 R2", "alu_op", int'(alu_op), exp_alu(op));
      @(posedge clk); #1;
    end
  endtask

  // Release reset 1 ns after an edge; fetch holds across two more edges (R1).
  task automatic release_reset();
    rst_n = 1'b1;
    opc = C_JAL;
    for (int i = 0; i < 2; i++) begin
      #3;
      chk("R1", "rf_we_in_sync", int'(rf_we), 0);
      chk("R1", "reg_dst_in_sync", int'(reg_dst), 2);
      chk("R1", "pc_we_in_sync", int'(pc_we), 0);
      @(posedge clk); #1;
    end
  endtask

  initial begin
    rst_n = 1'b0; opc = C_J; zf = 1'b1; sf = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) begin
      #3;
      chk("R1", "pc_we_reset", int'(pc_we), 0);
      chk("R1", "rf_we_reset", int'(rf_we), 0);
      chk("R1", "mem_we_reset", int'(mem_we), 0);
      chk("R1", "pc_src_reset_fetch", int'(pc_src), 2);
      @(posedge clk); #1;
    end
    release_reset();

    run_instr(C_JAL, 0, 0, 0);
    run_instr(C_J, 1, 0, 0);
    run_instr(C_JR, 0, 1, 0);
    run_instr(C_ADD, 1, 1, 0);
    run_instr(C_SUB, 0, 0, 0);
    run_instr(C_AND, 0, 0, 0);
    run_instr(C_SLL, 0, 0, 0);
    run_instr(C_SLT, 0, 0, 0);
    run_instr(C_ADDIU, 0, 0, 0);
    run_instr(C_ANDI, 0, 0, 0);
    run_instr(C_ORI, 1, 0, 0);
    run_instr(C_XORI, 0, 1, 0);
    run_instr(C_SLTI, 0, 0, 0);
    run_instr(C_LW, 0, 0, 0);
    run_instr(C_SW, 0, 0, 0);
    run_instr(C_BEQ, 1, 0, 0);
    run_instr(C_BEQ, 0, 1, 0);
    run_instr(C_BNE, 0, 0, 0);
    run_instr(C_BNE, 1, 0, 0);
    run_instr(C_BLTZ, 0, 1, 0);
    run_instr(C_BLTZ, 1, 0, 0);
    run_instr(C_BAD, 1, 1, 0);
    // flags inverted outside execute (R8)
    run_instr(C_BEQ, 1, 0, 1);
    run_instr(C_BNE, 1, 1, 1);
    run_instr(C_BLTZ, 0, 0, 1);
    run_instr(C_JR, 0, 0, 1);
    run_instr(C_ADD, 1, 1, 1);
    run_instr(C_LW, 1, 1, 1);

    // reset in the memory cycle of a store, after the strobe rose (R1)
    opc = C_SW; zf = 0; sf = 0;
    repeat (3) begin @(posedge clk); end
    #1; #2;
    rst_n = 1'b0;
    #1;
    chk("R1", "pc_we_async_clear", int'(pc_we), 0);
    chk("R1", "mem_we_async_clear", int'(mem_we), 0);
    @(posedge clk); #1;
    release_reset();
    run_instr(C_LW, 0, 0, 0);
    run_instr(C_SW, 1, 1, 0);
    run_instr(C_JAL, 1, 1, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule